// File: doc/BRIEF.md
# Processor Reset Release Sequencer

This block owns the active-low reset line of a companion application processor while the power management side brings up its supplies. After a start-up request it waits for a reset trigger. It accepts that trigger only while every enabled regulator reports a healthy output. When the trigger is accepted, the block runs a programmable reset delay and then releases the processor.

A fallback watchdog counts millisecond ticks from the start-up request. If the delay has not started by the end of the watchdog window, the delay starts anyway. When the cause is a missing trigger, a sticky timeout interrupt flag is also set. A fault reported by the delay element forces a shutdown request, sets the same flag and keeps the processor in reset. Dropping the start-up request returns everything to idle.

The analog delay element is modelled as a tick count. That count is sampled at the moment the delay starts.

Top module: `proc_reset_seq`

## Requirements
- R1: Out of reset, proc_rst_no is 0, timeout_irq_o is 0 and shutdown_o is 0.
- R2: In the waiting state, a cycle with trig_i=1 and no enabled under-voltage starts the delay. After dly_len_i ticks it counts down to zero, and in the following cycle proc_rst_no goes to 1. A length of 0 releases one cycle after the start.
- R3: While any regulator with uv_en_i[k]=1 has uv_i[k]=1, trig_i has no effect and proc_rst_no stays 0.
- R4: A regulator with uv_en_i[k]=0 is ignored, whatever its uv_i[k] value.
- R5: The watchdog counts tick_i pulses in the waiting state. On the WDOG_MS-th tick the delay starts. If trig_i=0 in that cycle, timeout_irq_o is set.
- R6: If the watchdog start happens while trig_i=1 but an enabled regulator is under-voltage, the delay still starts and timeout_irq_o is not set.
- R7: The delay length is taken from dly_len_i in the start cycle. Later changes to dly_len_i do not alter the release time.
- R8: timeout_irq_o stays 1 until a cycle with irq_clr_i=1 and no set condition. When set and clear occur in the same cycle, the flag stays 1.
- R9: With start_i=1, dly_err_i=1 moves the block to shutdown in any state. The block then raises shutdown_o, sets timeout_irq_o and holds proc_rst_no at 0. Only start_i=0 leaves shutdown.
- R10: start_i=0 returns the block to idle in the next cycle. proc_rst_no and shutdown_o go to 0, and both counters restart from zero on the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-up request (level) |
| trig_i | input | 1 | Reset trigger (level) |
| uv_i | input | N_REG | Per-regulator under-voltage flags |
| uv_en_i | input | N_REG | Per-regulator enable mask |
| dly_err_i | input | 1 | Delay element fault |
| tick_i | input | 1 | One-cycle millisecond tick |
| dly_len_i | input | DLY_W | Reset delay length in ticks |
| irq_clr_i | input | 1 | Clear pulse for the timeout flag |
| proc_rst_no | output | 1 | Processor reset, low holds in reset |
| timeout_irq_o | output | 1 | Sticky timeout interrupt flag |
| shutdown_o | output | 1 | Shutdown request |

## Verification
The bench builds the block with N_REG=3, WDOG_MS=12 and DLY_W=6. A 12-tick watchdog lets the fallback path fire many times within a short random run. A 6-bit length keeps release after long delays near the limit affordable. Three regulators allow masked and unmasked under-voltage mixes to cover every combination.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DELAY,
    ST_RELEASED,
    ST_SHUTDOWN
  } prs_state_e;
endpackage

// File: rtl/prs_wdog.sv
module prs_wdog #(
  parameter int WDOG_MS = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int WD_W = $clog2(WDOG_MS + 1);
  localparam logic [WD_W-1:0] LAST = WD_W'(WDOG_MS - 1);

  logic [WD_W-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i)             cnt_q <= '0;
    else if (tick_i && !expire_o) cnt_q <= cnt_q + 1'b1;
  end

  a_r5_wdog_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/prs_delay.sv
module prs_delay #(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] len_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic             done_o
);
  logic [DLY_W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (load_i)                      cnt_q <= len_i;
    else if (run_i && tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  a_r7_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && tick_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r7_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/prs_flag.sv
module prs_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
endmodule

// File: rtl/proc_reset_seq.sv
module proc_reset_seq
  import prs_pkg::*;
#(
  parameter int N_REG   = 4,
  parameter int WDOG_MS = 500,
  parameter int DLY_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             trig_i,
  input  logic [N_REG-1:0] uv_i,
  input  logic [N_REG-1:0] uv_en_i,
  input  logic             dly_err_i,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] dly_len_i,
  input  logic             irq_clr_i,
  output logic             proc_rst_no,
  output logic             timeout_irq_o,
  output logic             shutdown_o
);
  prs_state_e st_q, st_d;
  logic healthy, go_trig, wd_exp, dly_done, load_dly, irq_set;

  assign healthy = ~|(uv_i & uv_en_i);
  assign go_trig = (st_q == ST_WAIT) && trig_i && healthy;
  assign load_dly = start_i && !dly_err_i && (st_q == ST_WAIT) && (go_trig || wd_exp);
  assign irq_set = start_i && (dly_err_i ||
                   ((st_q == ST_WAIT) && wd_exp && !trig_i));

  prs_wdog #(.WDOG_MS(WDOG_MS)) i_wdog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (start_i && st_q == ST_WAIT),
    .tick_i  (tick_i),
    .expire_o(wd_exp)
  );

  prs_delay #(.DLY_W(DLY_W)) i_delay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_dly),
    .len_i (dly_len_i),
    .run_i (start_i && st_q == ST_DELAY),
    .tick_i(tick_i),
    .done_o(dly_done)
  );

  prs_flag i_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (irq_set),
    .clr_i (irq_clr_i),
    .q_o   (timeout_irq_o)
  );

  always_comb begin
    st_d = st_q;
    if (!start_i)       st_d = ST_IDLE;
    else if (dly_err_i) st_d = ST_SHUTDOWN;
    else begin
      unique case (st_q)
        ST_IDLE:  st_d = ST_WAIT;
        ST_WAIT:  if (go_trig || wd_exp) st_d = ST_DELAY;
        ST_DELAY: if (dly_done) st_d = ST_RELEASED;
        default:  st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign proc_rst_no = (st_q == ST_RELEASED);
  assign shutdown_o  = (st_q == ST_SHUTDOWN);

  a_r10_stop_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (!proc_rst_no && !shutdown_o));
  a_r9_err_shuts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && dly_err_i) |=> (shutdown_o && timeout_irq_o && !proc_rst_no));
  a_r9_shutdown_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutdown_o && start_i) |=> shutdown_o);
  a_r3_uv_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && start_i && !dly_err_i && !healthy && !wd_exp) |=> (st_q == ST_WAIT));
  a_r2_release_from_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(proc_rst_no) |-> ($past(st_q) == ST_DELAY));
endmodule

// File: tb/test_proc_reset_seq.sv
module test_proc_reset_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N_REG = 3;
  localparam int WDOG_MS = 12;
  localparam int DLY_W = 6;

  logic clk = 0, rst_ni = 0;
  logic start_i = 0, trig_i = 0, dly_err_i = 0, tick_i = 0, irq_clr_i = 0;
  logic [N_REG-1:0] uv_i = '0, uv_en_i = '0;
  logic [DLY_W-1:0] dly_len_i = '0;
  logic proc_rst_no, timeout_irq_o, shutdown_o;

  int total = 0, bad = 0;

  // model: 0 idle, 1 wait, 2 delay, 3 released, 4 shutdown
  int m_st = 0, m_wd = 0, m_dc = 0;
  logic m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  proc_reset_seq #(.N_REG(N_REG), .WDOG_MS(WDOG_MS), .DLY_W(DLY_W)) i_proc_reset_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .trig_i(trig_i), .uv_i(uv_i),
    .uv_en_i(uv_en_i), .dly_err_i(dly_err_i), .tick_i(tick_i), .dly_len_i(dly_len_i),
    .irq_clr_i(irq_clr_i), .proc_rst_no(proc_rst_no), .timeout_irq_o(timeout_irq_o),
    .shutdown_o(shutdown_o));

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit healthy_f();
    return (uv_i & uv_en_i) == '0;
  endfunction

  task automatic model_step();
    logic set;
    set = 0;
    if (!start_i) begin m_st = 0; m_wd = 0; end
    else if (dly_err_i) begin m_st = 4; set = 1; end
    else begin
      case (m_st)
        0: begin m_st = 1; m_wd = 0; end
        1: begin
          if (trig_i && healthy_f()) begin m_st = 2; m_dc = int'(dly_len_i); end
          else if (tick_i && m_wd == WDOG_MS-1) begin
            m_st = 2; m_dc = int'(dly_len_i); if (!trig_i) set = 1;
          end else if (tick_i) m_wd++;
        end
        2: if (m_dc == 0) m_st = 3; else if (tick_i) m_dc--;
        default: ;
      endcase
    end
    if (m_st != 1) m_wd = 0;
    if (set) m_irq = 1; else if (irq_clr_i) m_irq = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    #1;
    check(proc_rst_no == (m_st == 3), "R2 model reset", proc_rst_no, m_st == 3);
    check(timeout_irq_o == m_irq, "R8 model irq", timeout_irq_o, m_irq);
    check(shutdown_o == (m_st == 4), "R9 model shutdown", shutdown_o, m_st == 4);
  endtask

  task automatic cycn(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    bad++; total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check(proc_rst_no == 0 && timeout_irq_o == 0 && shutdown_o == 0, "R1 reset state",
          {proc_rst_no, timeout_irq_o, shutdown_o}, 0);
    rst_ni = 1;

    // R2: healthy trigger, length 5
    start_i = 1; uv_en_i = 3'b111; dly_len_i = 6'd5; tick_i = 1;
    cyc(); trig_i = 1; cyc(); trig_i = 0;
    cycn(5); check(proc_rst_no == 0, "R2 before release", proc_rst_no, 0);
    cyc();   check(proc_rst_no == 1, "R2 released", proc_rst_no, 1);
    check(timeout_irq_o == 0, "R2 no irq", timeout_irq_o, 0);

    // R10
    start_i = 0; cyc(); check(proc_rst_no == 0, "R10 stop reasserts", proc_rst_no, 1'b0);

    // R3: under-voltage blocks trigger (no ticks)
    start_i = 1; trig_i = 1; uv_i = 3'b010; tick_i = 0; dly_len_i = 0;
    cycn(20); check(proc_rst_no == 0, "R3 trigger blocked", proc_rst_no, 0);
    uv_i = 0; cycn(2); check(proc_rst_no == 1, "R3 release after heal", proc_rst_no, 1);

    // R4: masked regulator ignored
    start_i = 0; cyc(); start_i = 1; uv_i = 3'b100; uv_en_i = 3'b011;
    cycn(3); check(proc_rst_no == 1, "R4 masked uv ignored", proc_rst_no, 1);

    // R5: watchdog without trigger
    start_i = 0; trig_i = 0; uv_i = 0; uv_en_i = 3'b111; cyc();
    start_i = 1; tick_i = 1; cyc();
    cycn(WDOG_MS-1); check(timeout_irq_o == 0, "R5 irq before window", timeout_irq_o, 0);
    cyc(); check(timeout_irq_o == 1, "R5 irq at window", timeout_irq_o, 1);
    check(proc_rst_no == 0, "R5 still held", proc_rst_no, 0);
    cyc(); check(proc_rst_no == 1, "R5 release after fallback", proc_rst_no, 1);

    // R8: clear, then set wins
    irq_clr_i = 1; cyc(); irq_clr_i = 0;
    check(timeout_irq_o == 0, "R8 cleared", timeout_irq_o, 0);
    cycn(3); check(timeout_irq_o == 0, "R8 stays clear", timeout_irq_o, 0);
    dly_err_i = 1; irq_clr_i = 1; cyc(); irq_clr_i = 0; dly_err_i = 0;
    check(timeout_irq_o == 1, "R8 set wins", timeout_irq_o, 1);

    // R9
    check(shutdown_o == 1 && proc_rst_no == 0, "R9 shutdown entered", shutdown_o, 1);
    trig_i = 1; cycn(10);
    check(shutdown_o == 1 && proc_rst_no == 0, "R9 shutdown sticks", shutdown_o, 1);
    start_i = 0; cyc(); check(shutdown_o == 0, "R9 exit by stop", shutdown_o, 0);

    // R6: trigger high with under-voltage until window end
    irq_clr_i = 1; cyc(); irq_clr_i = 0;
    start_i = 1; uv_i = 3'b001; uv_en_i = 3'b001; trig_i = 1; tick_i = 1; cyc();
    cycn(WDOG_MS); check(timeout_irq_o == 0, "R6 no irq with trigger", timeout_irq_o, 0);
    cyc(); check(proc_rst_no == 1, "R6 release despite uv", proc_rst_no, 1);

    // R7: length sampled at start
    start_i = 0; uv_i = 0; cyc(); start_i = 1; dly_len_i = 6'd4; cyc(); cyc();
    dly_len_i = 6'd60; trig_i = 0;
    cycn(4); check(proc_rst_no == 0, "R7 before release", proc_rst_no, 0);
    cyc(); check(proc_rst_no == 1, "R7 sampled length", proc_rst_no, 1);

    // random mix, checked against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      start_i   = ($urandom % 80) != 0;
      trig_i    = ($urandom % 6) == 0;
      uv_i      = N_REG'($urandom) & N_REG'($urandom);
      uv_en_i   = N_REG'($urandom);
      dly_err_i = ($urandom % 300) == 0;
      tick_i    = ($urandom % 2) == 0;
      dly_len_i = DLY_W'($urandom % 10);
      irq_clr_i = ($urandom % 20) == 0;
      cyc();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule